// File: doc/BRIEF.md
# Register Rename Map Unit

This block sits at the allocate stage of an out-of-order core and turns the architectural register numbers carried by each micro-op into physical register tags. One micro-op may arrive per cycle with two source register numbers and an optional destination register number. The block looks up both sources in a speculative map table. When the micro-op writes a register, the block takes a fresh physical tag from a free list and points that architectural register at the new tag. Because each write gets its own physical register, write-after-write and write-after-read hazards disappear, while read-after-write dependencies are still honoured through the map.

The tag that the destination mapped to before the write is returned with the micro-op. Retirement logic later hands that tag back on the release port, and the free list makes it available again. If no free tag is available, a writing micro-op is stalled and has no effect. A reset restores the identity mapping and fills the free list with every remaining physical register.

Lookups, allocation and the stall signal are combinational in the cycle the micro-op is presented. Map and free-list updates take effect at the following clock edge.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, architectural register i maps to physical tag i for all 16 registers, and stall_o is low for a micro-op without a destination.
- R2: An accepted micro-op with a destination receives a tag (dst_tag_o) that differs from the previous mapping of that destination; the old mapping is not overwritten in place.
- R3: From the cycle after an accepted destination write, source lookups of that architectural register return the newly allocated tag.
- R4: Sources are looked up before the same micro-op's destination update, so a source equal to the destination returns the old tag.
- R5: prev_tag_o carries the tag that the destination mapped to before the accepted write.
- R6: The free list is first-in first-out. After reset, allocations return tags 16, 17, ..., 127 in that order, and released tags are then handed out in the order they were released.
- R7: stall_o is high exactly when ren_valid_i and dst_wr_i are high and no free tag is available; a stalled micro-op changes neither the map nor the free list.
- R8: A micro-op with dst_wr_i low, or any cycle with ren_valid_i low, consumes no tag and leaves the map unchanged.
- R9: One tag per cycle can be released through ret_valid_i and ret_tag_i, in the same cycle as an allocation. A tag released while the list is empty does not lift that cycle's stall but is allocatable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid_i | input | 1 | A micro-op is presented this cycle |
| src_a_i | input | 4 | First source architectural register |
| src_b_i | input | 4 | Second source architectural register |
| dst_wr_i | input | 1 | The micro-op writes a destination |
| dst_i | input | 4 | Destination architectural register |
| ret_valid_i | input | 1 | A tag is released this cycle |
| ret_tag_i | input | 7 | Physical tag being released |
| src_a_tag_o | output | 7 | Physical tag for the first source |
| src_b_tag_o | output | 7 | Physical tag for the second source |
| dst_tag_o | output | 7 | Newly allocated tag for the destination |
| prev_tag_o | output | 7 | Previous tag of the destination |
| stall_o | output | 1 | Micro-op not accepted: no free tag |

## Verification
The source tags, the new destination tag, the previous mapping and the stall flag all depend on the current inputs, so they are due in the same cycle. The bench drives at the falling edge and samples a quarter period later, before the rising edge. A map change or a released tag becomes visible one rising edge later, so every check of a later lookup or allocation uses the next micro-op presented after that edge. Expected tags come from closed-form values during the full allocation sweep (tag 16+k for the k-th allocation, previous tag k) and from a bench-side map and queue model elsewhere.

// File: rtl/rename_pkg.sv
// Shared defaults and helpers for the register rename map unit.
// Assumes: physical register count is a power of two and exceeds the
// architectural count.
package rename_pkg;
    parameter int unsigned DEF_ARCH_REGS = 16;
    parameter int unsigned DEF_PHYS_REGS = 128;

    // Advance a circular index that wraps at an arbitrary depth.
    function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
        return (p + 1 >= depth) ? 0 : p + 1;
    endfunction
endpackage

// File: rtl/rename_map_table.sv
// Speculative architectural-to-physical map with three read ports and
// one write port. Reads see the contents before this cycle's write.
// Assumes: the write tag is never a tag currently held by another entry.
module rename_map_table #(
    parameter int unsigned ARCH_REGS = rename_pkg::DEF_ARCH_REGS,
    parameter int unsigned TW        = 7,
    localparam int unsigned AW       = $clog2(ARCH_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [AW-1:0] rd_b_idx,
    input  logic [AW-1:0] rd_d_idx,
    output logic [TW-1:0] rd_a_tag,
    output logic [TW-1:0] rd_b_tag,
    output logic [TW-1:0] rd_d_tag,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [TW-1:0] wr_tag
);
    logic [TW-1:0] tbl_q [ARCH_REGS];

    // Lookups read the registered table, so they precede this cycle's write.
    always_comb begin
        rd_a_tag = tbl_q[rd_a_idx];
        rd_b_tag = tbl_q[rd_b_idx];
        rd_d_tag = tbl_q[rd_d_idx];
    end

    // Identity mapping on reset; otherwise record the newest tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(ARCH_REGS); i++) tbl_q[i] <= TW'(i);
        end else if (wr_en) begin
            tbl_q[wr_idx] <= wr_tag;
        end
    end

    // R3
    map_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tbl_q[$past(wr_idx)] == $past(wr_tag));
endmodule

// File: rtl/rename_free_list.sv
// Circular FIFO of free physical tags, one pop and one push per cycle.
// Reset fills it with tags FIRST .. FIRST+DEPTH-1 in ascending order.
// Assumes: pop is only requested when not empty; push never overfills.
module rename_free_list #(
    parameter int unsigned DEPTH = 112,
    parameter int unsigned TW    = 7,
    parameter int unsigned FIRST = 16,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_i,
    input  logic          push_i,
    input  logic [TW-1:0] push_tag_i,
    output logic [TW-1:0] head_tag_o,
    output logic          empty_o
);
    logic [TW-1:0] slots_q [DEPTH];
    logic [PW-1:0] head_q, tail_q;
    logic [CW-1:0] count_q;

    // Head entry and empty flag presented to the allocator.
    always_comb begin
        head_tag_o = slots_q[head_q];
        empty_o    = (count_q == '0);
    end

    // Storage: preload ascending tags on reset, append releases at the tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < int'(DEPTH); k++) slots_q[k] <= TW'(FIRST + k);
        end else if (push_i) begin
            slots_q[tail_q] <= push_tag_i;
        end
    end

    // Pointers and occupancy; list starts full so tail wraps to the head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= CW'(DEPTH);
        end else begin
            if (pop_i)  head_q <= PW'(rename_pkg::wrap_inc(int'(head_q), DEPTH));
            if (push_i) tail_q <= PW'(rename_pkg::wrap_inc(int'(tail_q), DEPTH));
            count_q <= count_q + CW'(push_i) - CW'(pop_i);
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> count_q < CW'(DEPTH));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> count_q != '0);
endmodule

// File: rtl/rename_map_unit.sv
// Register rename map unit: renames two sources and an optional destination
// per cycle, allocating a fresh physical tag for every destination write and
// returning the displaced tag for release at retirement.
// Assumes: released tags are exactly the displaced tags handed out earlier.
module rename_map_unit #(
    parameter int unsigned ARCH_REGS = rename_pkg::DEF_ARCH_REGS,
    parameter int unsigned PHYS_REGS = rename_pkg::DEF_PHYS_REGS,
    localparam int unsigned AW       = $clog2(ARCH_REGS),
    localparam int unsigned TW       = $clog2(PHYS_REGS),
    localparam int unsigned FREE_CAP = PHYS_REGS - ARCH_REGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid_i,
    input  logic [AW-1:0] src_a_i,
    input  logic [AW-1:0] src_b_i,
    input  logic          dst_wr_i,
    input  logic [AW-1:0] dst_i,
    input  logic          ret_valid_i,
    input  logic [TW-1:0] ret_tag_i,
    output logic [TW-1:0] src_a_tag_o,
    output logic [TW-1:0] src_b_tag_o,
    output logic [TW-1:0] dst_tag_o,
    output logic [TW-1:0] prev_tag_o,
    output logic          stall_o
);
    logic          free_empty;
    logic [TW-1:0] free_head;
    logic          alloc;

    // Accept a destination write only when a free tag exists.
    always_comb begin
        stall_o   = ren_valid_i && dst_wr_i && free_empty;
        alloc     = ren_valid_i && dst_wr_i && !free_empty;
        dst_tag_o = free_head;
    end

    rename_map_table #(.ARCH_REGS(ARCH_REGS), .TW(TW)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (src_a_i),
        .rd_b_idx (src_b_i),
        .rd_d_idx (dst_i),
        .rd_a_tag (src_a_tag_o),
        .rd_b_tag (src_b_tag_o),
        .rd_d_tag (prev_tag_o),
        .wr_en    (alloc),
        .wr_idx   (dst_i),
        .wr_tag   (free_head)
    );

    rename_free_list #(.DEPTH(FREE_CAP), .TW(TW), .FIRST(ARCH_REGS)) u_free (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop_i      (alloc),
        .push_i     (ret_valid_i),
        .push_tag_i (ret_tag_i),
        .head_tag_o (free_head),
        .empty_o    (free_empty)
    );

    // R2
    fresh_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> dst_tag_o != prev_tag_o);
endmodule

// File: tb/rename_map_unit_test.sv
// Bench for the rename map unit: full allocation sweep plus stall,
// release and ordering scenarios against a bench-side map and queue.
module rename_map_unit_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ren_valid_i, dst_wr_i, ret_valid_i;
    logic [3:0] src_a_i, src_b_i, dst_i;
    logic [6:0] ret_tag_i;
    logic [6:0] src_a_tag_o, src_b_tag_o, dst_tag_o, prev_tag_o;
    logic       stall_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int model [16];
    int fq [$];

    always #10 clk = ~clk;

    rename_map_unit uut (
        .clk(clk), .rst_n(rst_n), .ren_valid_i(ren_valid_i), .src_a_i(src_a_i),
        .src_b_i(src_b_i), .dst_wr_i(dst_wr_i), .dst_i(dst_i),
        .ret_valid_i(ret_valid_i), .ret_tag_i(ret_tag_i),
        .src_a_tag_o(src_a_tag_o), .src_b_tag_o(src_b_tag_o),
        .dst_tag_o(dst_tag_o), .prev_tag_o(prev_tag_o), .stall_o(stall_o)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Drive one cycle, check outputs before the edge, update the model.
    task automatic step(input string rq, input bit v, input int s1, input int s2,
                        input bit dw, input int d, input bit rv, input int rt);
        bit exp_stall;
        @(negedge clk);
        ren_valid_i = v; src_a_i = 4'(s1); src_b_i = 4'(s2);
        dst_wr_i = dw; dst_i = 4'(d); ret_valid_i = rv; ret_tag_i = 7'(rt);
        #5;
        exp_stall = v && dw && (fq.size() == 0);
        chk(rq, "stall", int'(stall_o), int'(exp_stall));
        if (v) begin
            chk(rq, "src_a tag", int'(src_a_tag_o), model[s1]);
            chk(rq, "src_b tag", int'(src_b_tag_o), model[s2]);
        end
        if (v && dw && !exp_stall) begin
            chk(rq, "dst tag", int'(dst_tag_o), fq[0]);
            chk(rq, "prev tag", int'(prev_tag_o), model[d]);
            model[d] = fq.pop_front();
        end
        if (rv) fq.push_back(rt);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = i;
        for (int t = 16; t < 128; t++) fq.push_back(t);
        rst_n = 1'b0; ren_valid_i = 0; dst_wr_i = 0; ret_valid_i = 0;
        src_a_i = 0; src_b_i = 0; dst_i = 0; ret_tag_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: identity map after reset, no stall without a destination
        for (int i = 0; i < 16; i++) begin
            step("R1", 1, i, 15 - i, 0, 0, 0, 0);
            chk("R1", "reset map", int'(src_a_tag_o), i);
        end

        // R6 R2 R4 R5: drain the whole free list; k-th allocation is 16+k, old tag is k
        for (int k = 0; k < 112; k++) begin
            step("R6", 1, k % 16, (k + 5) % 16, 1, k % 16, 0, 0);
            chk("R6", "alloc order", int'(dst_tag_o), 16 + k);
            chk("R2", "fresh tag", int'(dst_tag_o != prev_tag_o), 1);
            chk("R4", "src before dst", int'(src_a_tag_o), k);
            chk("R5", "prev tag", int'(prev_tag_o), k);
        end

        // R3: newest writer of register i in the sweep got tag 112+i
        for (int i = 0; i < 16; i++) begin
            step("R3", 1, i, (i + 1) % 16, 0, 0, 0, 0);
            chk("R3", "newest tag", int'(src_a_tag_o), 112 + i);
        end

        // R7: empty list stalls a writer and changes nothing
        step("R7", 1, 0, 1, 1, 2, 0, 0);
        chk("R7", "stall when empty", int'(stall_o), 1);
        step("R7", 1, 2, 2, 0, 0, 0, 0);
        chk("R7", "map kept after stall", int'(src_a_tag_o), 114);

        // R9: release while empty keeps this cycle stalled, tag usable next cycle
        step("R9", 1, 0, 0, 1, 3, 1, 0);
        chk("R9", "still stalled", int'(stall_o), 1);
        step("R9", 1, 3, 3, 1, 3, 0, 0);
        chk("R9", "released tag allocated", int'(dst_tag_o), 0);
        chk("R9", "old tag of r3", int'(src_a_tag_o), 115);

        // R6: release tags 1..8, then allocate while releasing 9..16
        for (int j = 1; j <= 8; j++) step("R6", 0, 0, 0, 0, 0, 1, j);
        for (int j = 1; j <= 8; j++) begin
            step("R9", 1, 4, 5, 1, j % 16, 1, j + 8);
            chk("R6", "release order", int'(dst_tag_o), j);
        end

        // R8: idle and no-destination cycles take no tag
        step("R8", 0, 0, 0, 1, 6, 0, 0);
        step("R8", 1, 6, 7, 0, 6, 0, 0);
        for (int j = 9; j <= 16; j++) begin
            step("R8", 1, 6, 7, 1, 6, 0, 0);
            chk("R8", "head not consumed", int'(dst_tag_o), j);
        end
        step("R7", 1, 0, 0, 1, 0, 0, 0);

        @(negedge clk);
        ren_valid_i = 0; dst_wr_i = 0; ret_valid_i = 0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule